// File: doc/BRIEF.md
# Configuration Bit-Bang Serializer

This block turns a stream of configuration bytes into a slow sequence of pin states that clock a programmable device through a serial loading port. Each pin state is an 8-bit word. A one-cycle strobe marks each new word, and a programmable step counter sets the spacing between words. A load starts with a short fixed preamble. The block then waits for the target to report that it is ready. After that it takes bytes from a valid/ready source and sends each one out as sixteen words: two for every bit, starting with the most significant bit.

A load begins with a start pulse. It ends in one of two ways. If it succeeds, the done flag is raised with the final word of the byte marked as last. If the readiness line stays low past a programmable limit, the error flag is raised instead. Either way the block returns to idle and holds the flag until the next start. The readiness line is taken from one bit of an 8-bit pin readback and passes through a synchronizer.

Top module: `cfg_bitbang_ser`

## Requirements
- R1: Out of reset, `pin_o` is 0x00, and `pin_stb_o`, `busy_o`, `done_o`, `err_o` and `byte_ready_o` are all low.
- R2: After `start_i` is accepted, the first nine words are 0x03, 0x03, and then seven words of 0x01.
- R3: After the preamble, the block waits for bit 5 of `pins_rd_i` to be high (after a two-flop synchronizer) before it accepts any byte. The other readback bits have no effect.
- R4: Bit mapping:
  - Each byte is sent most significant bit first.
  - Each bit becomes two words. The first carries the data on bit 6 (0x40 for a one, 0x00 for a zero) with the clock on bit 0 high (0x01). The second carries the same data with bit 0 low.
  - An image of N bytes gives exactly 16·N words after the preamble.
- R5: Every new word is marked by exactly one strobe cycle. `pin_o` holds its value between strobes, and no strobe occurs outside a load.
- R6: Word pacing:
  - During the preamble, consecutive strobes are exactly `div_i`+1 cycles apart.
  - During streaming the same spacing holds while the byte source keeps a byte ready.
  - With `div_i` = 0, one word is sent per cycle.
- R7: Completion:
  - `done_o` rises in the same cycle as the strobe of the clock-low word for bit 0 of the byte presented with `byte_last_i` high.
  - `busy_o` falls at that point.
  - `done_o` stays high until the next accepted start.
- R8: If readiness stays low, `err_o` rises exactly `timeout_i`+1 cycles after the last preamble strobe. `busy_o` falls at the same time and no further word is sent.
- R9: A `start_i` pulse while `busy_o` is high is ignored; the running load continues unchanged.
- R10: `byte_ready_o` is high only while streaming. Once a byte flagged last has been accepted, no further byte is accepted in that load.
- R11: An accepted start clears `done_o` and `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a load (ignored while busy) |
| div_i | input | DIV_W | Step divider; words are div_i+1 cycles apart |
| timeout_i | input | TO_W | Readiness wait limit in cycles |
| pins_rd_i | input | 8 | Pin readback; bit 5 is the readiness line |
| byte_valid_i | input | 1 | Configuration byte offered |
| byte_data_i | input | BYTE_W | Configuration byte |
| byte_last_i | input | 1 | Offered byte is the final one of the image |
| byte_ready_o | output | 1 | Byte accepted on this cycle if valid |
| pin_o | output | 8 | Current pin-state word |
| pin_stb_o | output | 1 | One-cycle strobe marking a new word |
| busy_o | output | 1 | A load is in progress |
| done_o | output | 1 | Last load completed |
| err_o | output | 1 | Last load aborted on readiness timeout |

## Verification
The pacing assertion assumes that `div_i` is constant for the whole load. The bench therefore sets it before each start and never changes it mid-load. It also keeps `timeout_i` constant.

The stream-spacing checks assume the byte source is never empty while streaming. The bench queues a whole image before starting, so a byte is always offered whenever `byte_ready_o` is high. It excludes only the first stream word, whose latency depends on the readiness handshake.

Readiness is raised and held as a level for many cycles, which keeps it within what the synchronizer expects.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_WAIT,
    ST_STREAM
  } cfg_state_e;

  localparam int unsigned WORD_W     = 8;
  localparam int unsigned DATA_BIT   = 6;
  localparam int unsigned CLK_BIT    = 0;
  localparam int unsigned RDY_BIT    = 5;
  localparam int unsigned PRE_LEN    = 9;
  localparam int unsigned PRE_HI_LEN = 2;
  localparam logic [WORD_W-1:0] PRE_WORD_HI = 8'h03;
  localparam logic [WORD_W-1:0] PRE_WORD_LO = 8'h01;

  function automatic logic [WORD_W-1:0] bit_word(input logic d, input logic clk_hi);
    logic [WORD_W-1:0] w;
    w = '0;
    w[DATA_BIT] = d;
    w[CLK_BIT]  = clk_hi;
    return w;
  endfunction

endpackage

// File: rtl/cfgser_sync.sv
module cfgser_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];

endmodule

// File: rtl/cfgser_pacer.sv
module cfgser_pacer #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             avail_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;

  // saturates at div_i while no word is available
  assign tick_o = run_i && avail_i && (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else if (cnt_q < div_i)     cnt_q <= cnt_q + 1'b1;
  end

  // R6
  min_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && (div_i != '0)) |=> !tick_o);

endmodule

// File: rtl/cfgser_unpack.sv
module cfgser_unpack
  import cfgser_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              en_i,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  input  logic              adv_i,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_final_o
);

  localparam int unsigned IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(BYTE_W - 1);

  logic              hold_vld_q, hold_last_q, seen_last_q;
  logic [BYTE_W-1:0] hold_data_q;
  logic              sh_vld_q, sh_last_q, phase_q;
  logic [BYTE_W-1:0] sh_data_q;
  logic [IDX_W-1:0]  idx_q;

  logic accept, end_of_byte, load;

  assign in_ready_o   = en_i && !hold_vld_q && !seen_last_q;
  assign accept       = in_valid_i && in_ready_o;
  assign end_of_byte  = (idx_q == IDX_END) && phase_q;
  assign load         = hold_vld_q && (!sh_vld_q || (adv_i && end_of_byte));

  assign word_vld_o   = sh_vld_q;
  assign word_o       = bit_word(sh_data_q[BYTE_W-1], !phase_q);
  assign word_final_o = sh_vld_q && sh_last_q && end_of_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_vld_q  <= 1'b0;
      hold_last_q <= 1'b0;
      hold_data_q <= '0;
      seen_last_q <= 1'b0;
    end else if (flush_i) begin
      hold_vld_q  <= 1'b0;
      hold_last_q <= 1'b0;
      seen_last_q <= 1'b0;
    end else if (accept) begin
      hold_vld_q  <= 1'b1;
      hold_data_q <= in_data_i;
      hold_last_q <= in_last_i;
      seen_last_q <= in_last_i;
    end else if (load) begin
      hold_vld_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_vld_q  <= 1'b0;
      sh_last_q <= 1'b0;
      sh_data_q <= '0;
      idx_q     <= '0;
      phase_q   <= 1'b0;
    end else if (flush_i) begin
      sh_vld_q  <= 1'b0;
      sh_last_q <= 1'b0;
      idx_q     <= '0;
      phase_q   <= 1'b0;
    end else if (load) begin
      sh_vld_q  <= 1'b1;
      sh_data_q <= hold_data_q;
      sh_last_q <= hold_last_q;
      idx_q     <= '0;
      phase_q   <= 1'b0;
    end else if (adv_i && sh_vld_q) begin
      if (!phase_q) begin
        phase_q <= 1'b1;
      end else begin
        phase_q <= 1'b0;
        if (end_of_byte) begin
          sh_vld_q <= 1'b0;
        end else begin
          idx_q     <= idx_q + 1'b1;
          sh_data_q <= sh_data_q << 1;
        end
      end
    end
  end

  // R10
  last_blocks_input_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || flush_i)
    (accept && in_last_i) |=> !in_ready_o);

  // R4
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || flush_i)
    (adv_i && sh_vld_q && !phase_q) |=> (word_o[DATA_BIT] == $past(word_o[DATA_BIT])));

endmodule

// File: rtl/cfg_bitbang_ser.sv
module cfg_bitbang_ser
  import cfgser_pkg::*;
#(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned TO_W        = 16,
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [TO_W-1:0]   timeout_i,
  input  logic [7:0]        pins_rd_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_data_i,
  input  logic              byte_last_i,
  output logic              byte_ready_o,
  output logic [7:0]        pin_o,
  output logic              pin_stb_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);

  localparam int unsigned PRE_IDX_W = $clog2(PRE_LEN);
  localparam logic [PRE_IDX_W-1:0] PRE_END = PRE_IDX_W'(PRE_LEN - 1);

  cfg_state_e           state_q;
  logic [PRE_IDX_W-1:0] pre_idx_q;
  logic [TO_W-1:0]      wait_cnt_q;

  logic              rdy_s, run, avail, tick, adv, flush;
  logic              word_vld, word_final;
  logic [WORD_W-1:0] word, pre_word;
  logic              unused_pins;

  assign unused_pins = ^pins_rd_i;

  cfgser_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_rd_i[RDY_BIT]),
    .q_o    (rdy_s)
  );

  assign run   = (state_q == ST_PRE) || (state_q == ST_STREAM);
  assign avail = (state_q == ST_PRE) ? 1'b1 : word_vld;
  assign adv   = tick && (state_q == ST_STREAM);
  assign flush = (state_q == ST_IDLE) && start_i;

  cfgser_pacer #(.DIV_W(DIV_W)) u_pacer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .avail_i (avail),
    .div_i   (div_i),
    .tick_o  (tick)
  );

  cfgser_unpack #(.BYTE_W(BYTE_W)) u_unpack (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush),
    .en_i         (state_q == ST_STREAM),
    .in_valid_i   (byte_valid_i),
    .in_data_i    (byte_data_i),
    .in_last_i    (byte_last_i),
    .in_ready_o   (byte_ready_o),
    .adv_i        (adv),
    .word_vld_o   (word_vld),
    .word_o       (word),
    .word_final_o (word_final)
  );

  assign pre_word = (pre_idx_q < PRE_IDX_W'(PRE_HI_LEN)) ? PRE_WORD_HI : PRE_WORD_LO;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_o     <= '0;
      pin_stb_o <= 1'b0;
    end else begin
      pin_stb_o <= tick;
      if (tick) pin_o <= (state_q == ST_PRE) ? pre_word : word;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      pre_idx_q  <= '0;
      wait_cnt_q <= '0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q   <= ST_PRE;
            pre_idx_q <= '0;
            done_o    <= 1'b0;
            err_o     <= 1'b0;
          end
        end
        ST_PRE: begin
          if (tick) begin
            if (pre_idx_q == PRE_END) begin
              state_q    <= ST_WAIT;
              wait_cnt_q <= '0;
            end else begin
              pre_idx_q <= pre_idx_q + 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (rdy_s) begin
            state_q <= ST_STREAM;
          end else if (wait_cnt_q == timeout_i) begin
            err_o   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            wait_cnt_q <= wait_cnt_q + 1'b1;
          end
        end
        ST_STREAM: begin
          if (tick && word_final) begin
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);

  // R10
  ready_only_streaming_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ready_o |-> (state_q == ST_STREAM));

  // R7
  done_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  // R5
  stb_in_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_stb_o |-> ($past(state_q) == ST_PRE || $past(state_q) == ST_STREAM));

  // R8
  err_from_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> ($past(state_q) == ST_WAIT));

  // R7
  done_on_clk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (pin_stb_o && !pin_o[CLK_BIT]));

endmodule

// File: tb/cfg_bitbang_ser_tb.sv
module cfg_bitbang_ser_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  div_i = '0;
  logic [15:0] timeout_i = 16'd1000;
  logic [7:0]  pins_rd_i = '0;
  logic        byte_valid_i = 1'b0;
  logic [7:0]  byte_data_i = '0;
  logic        byte_last_i = 1'b0;
  logic        byte_ready_o;
  logic [7:0]  pin_o;
  logic        pin_stb_o, busy_o, done_o, err_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [8:0] feed_q[$];
  logic [7:0] exp_q[$];
  int   wcount = 0;
  int   since = 0;
  int   div_cfg = 0;
  bit   tail_done = 1'b0;
  logic [7:0] last_word = '0;

  cfg_bitbang_ser dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .div_i(div_i),
    .timeout_i(timeout_i), .pins_rd_i(pins_rd_i), .byte_valid_i(byte_valid_i),
    .byte_data_i(byte_data_i), .byte_last_i(byte_last_i), .byte_ready_o(byte_ready_o),
    .pin_o(pin_o), .pin_stb_o(pin_stb_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    #1;
  endtask

  // reference model: expected word queue, gap and hold rules
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (pin_stb_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5", "unexpected strobe", pin_o, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(pin_o == e, (wcount < 9) ? "R2" : "R4", "word", pin_o, e);
          if ((wcount >= 1 && wcount <= 8) || wcount >= 10)
            chk(since + 1 == div_cfg + 1, "R6", "step gap", since + 1, div_cfg + 1);
          if (exp_q.size() > 0 || !tail_done) begin
            chk(!done_o, "R7", "done early", done_o, 0);
          end else begin
            chk(done_o, "R7", "done with final word", done_o, 1);
            chk(!busy_o, "R7", "busy after final word", busy_o, 0);
          end
        end
        wcount++;
        since = 0;
        last_word = pin_o;
      end else begin
        since++;
        chk(pin_o == last_word, "R5", "hold between strobes", pin_o, last_word);
      end
    end
  end

  // byte source: offers the queue front, pops after an accepting edge
  initial begin
    forever begin
      @(negedge clk_i);
      if (!byte_valid_i && feed_q.size() > 0) begin
        byte_valid_i = 1'b1;
        {byte_last_i, byte_data_i} = feed_q[0];
      end
      if (byte_valid_i && byte_ready_o) begin
        @(posedge clk_i);
        #2;
        void'(feed_q.pop_front());
        if (feed_q.size() > 0) {byte_last_i, byte_data_i} = feed_q[0];
        else byte_valid_i = 1'b0;
      end
    end
  end

  task automatic queue_image(input logic [7:0] img[$]);
    exp_q.delete();
    exp_q.push_back(8'h03); exp_q.push_back(8'h03);
    for (int i = 0; i < 7; i++) exp_q.push_back(8'h01);
    foreach (img[k]) begin
      feed_q.push_back({(k == img.size() - 1), img[k]});
      for (int b = 7; b >= 0; b--) begin
        exp_q.push_back(img[k][b] ? 8'h41 : 8'h01);
        exp_q.push_back(img[k][b] ? 8'h40 : 8'h00);
      end
    end
  endtask

  task automatic do_load(input int dv, input logic [7:0] img[$], input int rdy_delay,
                         input bit mid_start);
    int guard;
    pins_rd_i = 8'h00;
    div_i = 8'(dv); div_cfg = dv; timeout_i = 16'd1000;
    tail_done = 1'b1;
    queue_image(img);
    wcount = 0;
    step(); start_i = 1'b1;
    step(); start_i = 1'b0;
    chk(!done_o && !err_o, "R11", "flags cleared by start", {done_o, err_o}, 0);
    chk(busy_o, "R11", "busy after start", busy_o, 1);
    guard = 0;
    while (wcount < 9 && guard < 2000) begin step(); guard++; end
    for (int i = 0; i < rdy_delay; i++) begin
      step();
      chk(!byte_ready_o, "R3", "no byte before readiness", byte_ready_o, 0);
      chk(!pin_stb_o, "R3", "no word before readiness", pin_stb_o, 0);
    end
    pins_rd_i = 8'h20;
    if (mid_start) begin
      guard = 0;
      while (wcount < 20 && guard < 2000) begin step(); guard++; end
      start_i = 1'b1; step(); start_i = 1'b0;
      chk(busy_o, "R9", "start while busy ignored", busy_o, 1);
    end
    guard = 0;
    while (!done_o && guard < 20000) begin step(); guard++; end
    chk(exp_q.size() == 0, "R4", "16 words per byte", exp_q.size(), 0);
    chk(feed_q.size() == 0, "R10", "all bytes taken", feed_q.size(), 0);
    for (int i = 0; i < 5; i++) step();
    chk(done_o && !busy_o, "R7", "done held in idle", {done_o, busy_o}, 2);
    chk(!byte_ready_o, "R10", "no ready in idle", byte_ready_o, 0);
  endtask

  initial begin
    logic [7:0] img[$];
    #3000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] img[$];
    int guard;
    repeat (3) @(negedge clk_i);
    chk(pin_o == 8'h00, "R1", "reset pin", pin_o, 0);
    chk(!pin_stb_o && !busy_o && !done_o && !err_o && !byte_ready_o, "R1",
        "reset flags", {pin_stb_o, busy_o, done_o, err_o, byte_ready_o}, 0);
    #1 rst_ni = 1'b1;
    step();

    img = '{8'hA5, 8'h3C, 8'hFF};
    do_load(3, img, 30, 1'b0);

    img = '{8'h80, 8'h01, 8'h00, 8'h7E};
    do_load(0, img, 4, 1'b1);

    img = '{8'hC3};
    do_load(2, img, 0, 1'b0);

    // readiness timeout, other readback bits high
    pins_rd_i = 8'hDF;
    div_i = 8'd1; div_cfg = 1; timeout_i = 16'd20;
    tail_done = 1'b0;
    img = {};
    queue_image(img);
    wcount = 0;
    step(); start_i = 1'b1;
    step(); start_i = 1'b0;
    chk(!done_o, "R11", "done cleared by start", done_o, 0);
    guard = 0;
    while (wcount < 9 && guard < 2000) begin step(); guard++; end
    for (int k = 1; k <= 21; k++) begin
      step();
      if (k == 20) chk(!err_o && busy_o, "R8", "no error before limit", {err_o, busy_o}, 1);
      if (k == 21) chk(err_o && !busy_o, "R8", "error at limit", {err_o, busy_o}, 2);
      if (k <= 20) chk(!byte_ready_o, "R3", "other pins ignored", byte_ready_o, 0);
    end
    for (int i = 0; i < 10; i++) step();
    chk(err_o && !done_o, "R8", "error held, no words", {err_o, done_o}, 2);

    img = '{8'h5A};
    do_load(1, img, 2, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule